// File: doc/BRIEF.md
# Frequency Synthesizer Serial Programming Controller

This block sits on the master side of a three-wire link to an integer-N frequency synthesizer. The link has a serial clock, a data line and a latch strobe. The host hands over 24-bit latch words through a valid/ready handshake. The block shifts each word out most significant bit first. It changes data only while the serial clock is low, because the device captures on the rising edge. After the last bit it raises the latch strobe, which moves the word into the addressed register inside the device.

The block also owns the device power line. When power is requested, it raises chip enable and writes three words, set as parameters, in a fixed order: the initialization latch first, then the reference divider latch, then the feedback divider latch. The two least significant bits of every word are the latch address that the device decodes: 00 selects the reference divider, 01 the feedback divider, 10 the function latch and 11 the initialization latch. After any word addressed 01, the block watches the device's lock-detect pin for a programmable number of clocks. It then reports either locked or timed out, and only after that does it accept another word.

The serial clock is the system clock divided by 2*HALF_DIV. An elaboration check rejects any setting that would push the serial clock above 20 MHz.

Top module: `synth_prog_ctrl`

## Requirements
- R1: While rst_n is low and after its release with pwr_on_i low, chip_en_o, in_ready_o, ser_clk_o, ser_data_o, ser_le_o, locked_o and timeout_o are all 0.
- R2: One clock after pwr_on_i is sampled high in the powered-down state, chip_en_o goes to 1. The three power-up words then go out in the order INIT_WORD (address 11), RCNT_WORD (address 00), NCNT_WORD (address 01).
- R3: Each word is sent as 24 bits, most significant first. ser_clk_o spends HALF_DIV clocks low and then HALF_DIV clocks high for each bit. ser_data_o changes only while ser_clk_o is low. The first bit appears one clock after the word is accepted.
- R4: ser_le_o stays low while bits are shifted. Once the 24th bit's high phase ends, ser_le_o is high for 2*HALF_DIV clocks with ser_clk_o low. It then stays low for at least HALF_DIV clocks before the next word starts.
- R5: in_ready_o is 0 until the power-up sequence and its lock poll have finished. It is also 0 during every transfer and every poll. A word held on in_valid_i while in_ready_o is 0 is accepted only at the first clock where in_ready_o is 1.
- R6: After a word addressed 01, locked_o and timeout_o are cleared and the lock-detect pin is watched through a two-flop synchronizer. The first synchronized high sets locked_o. If no high arrives within POLL_CYCLES clocks, timeout_o is set instead. in_ready_o returns to 1 in the same clock either flag is set.
- R7: Words with address 00, 10 or 11 return in_ready_o to 1 without a poll and leave locked_o and timeout_o unchanged.
- R8: A low pwr_on_i is acted on only when the block is idle, meaning no transfer and no poll. chip_en_o falls one clock later. A transfer already in progress finishes first.
- R9: Raising pwr_on_i again after a power-down repeats the full three-word power-up sequence and its poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_on_i | input | 1 | Request to power and program the synthesizer |
| in_valid_i | input | 1 | Host word valid |
| in_data_i | input | 24 | Host latch word, address in bits 1:0 |
| in_ready_o | output | 1 | Block can take a host word |
| ser_clk_o | output | 1 | Serial clock to the device |
| ser_data_o | output | 1 | Serial data to the device |
| ser_le_o | output | 1 | Latch strobe, rising edge commits the word |
| chip_en_o | output | 1 | Device power enable |
| lock_det_i | input | 1 | Asynchronous lock-detect level from the device |
| locked_o | output | 1 | Last poll saw lock |
| timeout_o | output | 1 | Last poll expired without lock |

## Verification
A wrong bit or half-period counter shows up on ser_clk_o, ser_data_o or ser_le_o within one serial half period, because the bench predicts every pin level on every clock. A wrong sequencing state shows as in_ready_o or chip_en_o differing from the prediction. This happens either at the clock where the next power-up word should start or where the poll should end, at most POLL_CYCLES clocks after a latch strobe. A broken address decode shows as a poll that is missing or extra right after the strobe, and the bench also decodes the captured serial words and compares them against the expected order.

// File: rtl/synth_prog_pkg.sv
// Shared constants and types for the synthesizer programming controller.
// Assumes the device decodes the latch address from the two lowest word bits.
package synth_prog_pkg;
    localparam int unsigned WORD_BITS   = 24;
    localparam int unsigned ADDR_BITS   = 2;
    localparam int unsigned INIT_WRITES = 3;
    localparam int unsigned MAX_SCLK_HZ = 20_000_000;

    typedef logic [WORD_BITS-1:0] latch_word_t;
    typedef logic [ADDR_BITS-1:0] latch_addr_t;

    // Address code of the feedback (N) divider latch; a write here starts a lock poll.
    localparam latch_addr_t ADDR_NCOUNT = 2'b01;

    typedef enum logic [1:0] {
        CTL_OFF,
        CTL_INIT,
        CTL_IDLE,
        CTL_XFER
    } ctl_state_t;
endpackage

// File: rtl/sclk_tick.sv
// Half-period timer for the serial clock.
// Emits one tick every HALF_DIV system clocks while run is high; it restarts from zero whenever run is low.
module sclk_tick #(
    parameter int unsigned HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    // Count system clocks inside one serial half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/word_shifter.sv
// Serializer for one latch word: 24 low/high bit phases, then a strobe of two half periods, then one idle half period.
// Assumes start is only raised while busy is low. All pins are registered, so they lag the internal phase by one clock.
module word_shifter
    import synth_prog_pkg::*;
#(
    parameter int unsigned HALF_DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  latch_word_t word,
    output logic        busy,
    output logic        sclk_o,
    output logic        sdata_o,
    output logic        le_o
);
    localparam int unsigned SHIFT_HP = 2 * WORD_BITS;
    localparam int unsigned LATCH_HP = 2;
    localparam int unsigned GAP_HP   = 1;
    localparam int unsigned LAST_HP  = SHIFT_HP + LATCH_HP + GAP_HP - 1;
    localparam int unsigned HW       = $clog2(LAST_HP + 1);

    logic          active;
    logic [HW-1:0] hp;
    latch_word_t   shreg;
    logic          tick;
    logic          in_shift;
    logic          in_latch;

    sclk_tick #(.HALF_DIV(HALF_DIV)) i_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (active),
        .tick (tick)
    );

    assign busy     = active;
    assign in_shift = hp < HW'(SHIFT_HP);
    assign in_latch = (hp >= HW'(SHIFT_HP)) && (hp < HW'(SHIFT_HP + LATCH_HP));

    // Step through half periods and shift the word on each falling serial edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            hp     <= '0;
            shreg  <= '0;
        end else if (start && !active) begin
            active <= 1'b1;
            hp     <= '0;
            shreg  <= word;
        end else if (tick) begin
            if (hp == HW'(LAST_HP)) begin
                active <= 1'b0;
            end else begin
                hp <= hp + 1'b1;
            end
            if (hp[0] && in_shift) begin
                shreg <= {shreg[WORD_BITS-2:0], 1'b0};
            end
        end
    end

    // Register the three pins from the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_o  <= 1'b0;
            sdata_o <= 1'b0;
            le_o    <= 1'b0;
        end else begin
            sclk_o  <= active && in_shift && hp[0];
            sdata_o <= active && in_shift && shreg[WORD_BITS-1];
            le_o    <= active && in_latch;
        end
    end
endmodule

// File: rtl/lock_poll.sv
// Lock-detect poll: synchronizes the raw lock pin and, once started, waits up to POLL_CYCLES clocks for it.
// Assumes poll_start is never raised while a poll is active. The result flags hold until the next start.
module lock_poll #(
    parameter int unsigned POLL_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic poll_start,
    input  logic lock_raw,
    output logic active,
    output logic locked_o,
    output logic timeout_o
);
    localparam int unsigned CW = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(POLL_CYCLES - 1);

    logic          sync1;
    logic          sync2;
    logic [CW-1:0] cnt;

    // Two-flop synchronizer for the asynchronous lock pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
        end else begin
            sync1 <= lock_raw;
            sync2 <= sync1;
        end
    end

    // Run the poll window and latch its outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            cnt       <= '0;
            locked_o  <= 1'b0;
            timeout_o <= 1'b0;
        end else if (poll_start) begin
            active    <= 1'b1;
            cnt       <= '0;
            locked_o  <= 1'b0;
            timeout_o <= 1'b0;
        end else if (active) begin
            if (sync2) begin
                locked_o <= 1'b1;
                active   <= 1'b0;
            end else if (cnt == LAST) begin
                timeout_o <= 1'b1;
                active    <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/seq_ctrl.sv
// Sequencer: power state, the three power-up writes, host word acceptance, and poll launch after N-latch writes.
// Assumes the shifter raises busy one clock after start and that poll_active covers the whole poll.
module seq_ctrl
    import synth_prog_pkg::*;
#(
    parameter latch_word_t INIT_WORD = 24'h0D8093,
    parameter latch_word_t RCNT_WORD = 24'h100050,
    parameter latch_word_t NCNT_WORD = 24'h003201
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pwr_on_i,
    input  logic        in_valid_i,
    input  latch_word_t in_data_i,
    input  logic        sh_busy,
    input  logic        poll_active,
    output logic        in_ready_o,
    output logic        chip_en_o,
    output logic        sh_start,
    output latch_word_t sh_word,
    output logic        poll_start
);
    localparam latch_word_t SEQ_WORDS [INIT_WRITES] = '{INIT_WORD, RCNT_WORD, NCNT_WORD};
    localparam logic [1:0]  LAST_IDX = 2'(INIT_WRITES - 1);

    ctl_state_t  state;
    logic [1:0]  idx;
    logic        inflight;
    latch_addr_t cur_addr;
    logic        accept;
    logic        init_launch;
    logic        complete;

    assign in_ready_o  = (state == CTL_IDLE) && !poll_active && pwr_on_i;
    assign accept      = in_ready_o && in_valid_i;
    assign init_launch = (state == CTL_INIT) && !inflight && !sh_busy;
    assign complete    = inflight && !sh_busy;
    assign sh_start    = accept || init_launch;
    assign sh_word     = accept ? in_data_i : SEQ_WORDS[idx];
    assign poll_start  = complete && (cur_addr == ADDR_NCOUNT);
    assign chip_en_o   = (state != CTL_OFF);

    // Advance the power and transfer state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= CTL_OFF;
            idx      <= '0;
            inflight <= 1'b0;
            cur_addr <= '0;
        end else begin
            case (state)
                CTL_OFF: begin
                    if (pwr_on_i) begin
                        state <= CTL_INIT;
                        idx   <= '0;
                    end
                end
                CTL_INIT: begin
                    if (init_launch) begin
                        inflight <= 1'b1;
                        cur_addr <= sh_word[ADDR_BITS-1:0];
                    end else if (complete) begin
                        inflight <= 1'b0;
                        if (idx == LAST_IDX) begin
                            state <= CTL_IDLE;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                CTL_IDLE: begin
                    if (accept) begin
                        state    <= CTL_XFER;
                        inflight <= 1'b1;
                        cur_addr <= in_data_i[ADDR_BITS-1:0];
                    end else if (!poll_active && !pwr_on_i) begin
                        state <= CTL_OFF;
                    end
                end
                default: begin
                    if (complete) begin
                        state    <= CTL_IDLE;
                        inflight <= 1'b0;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/synth_prog_ctrl.sv
// Top of the synthesizer programming controller: sequencer, word shifter and lock poll.
// Assumes SYS_CLK_HZ is the frequency of clk; elaboration fails if the serial clock would exceed the device limit.
module synth_prog_ctrl
    import synth_prog_pkg::*;
#(
    parameter int unsigned SYS_CLK_HZ  = 50_000_000,
    parameter int unsigned HALF_DIV    = 2,
    parameter int unsigned POLL_CYCLES = 1000,
    parameter latch_word_t INIT_WORD   = 24'h0D8093,
    parameter latch_word_t RCNT_WORD   = 24'h100050,
    parameter latch_word_t NCNT_WORD   = 24'h003201
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pwr_on_i,
    input  logic        in_valid_i,
    input  logic [23:0] in_data_i,
    output logic        in_ready_o,
    output logic        ser_clk_o,
    output logic        ser_data_o,
    output logic        ser_le_o,
    output logic        chip_en_o,
    input  logic        lock_det_i,
    output logic        locked_o,
    output logic        timeout_o
);
    generate
        if (HALF_DIV == 0) begin : g_div_zero
            $error("HALF_DIV must be at least 1");
        end else if (SYS_CLK_HZ / (2 * HALF_DIV) > MAX_SCLK_HZ) begin : g_sclk_fast
            $error("serial clock above 20 MHz, raise HALF_DIV");
        end
    endgenerate

    logic        sh_start;
    latch_word_t sh_word;
    logic        sh_busy;
    logic        poll_start;
    logic        poll_active;

    seq_ctrl #(
        .INIT_WORD(INIT_WORD),
        .RCNT_WORD(RCNT_WORD),
        .NCNT_WORD(NCNT_WORD)
    ) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_on_i   (pwr_on_i),
        .in_valid_i (in_valid_i),
        .in_data_i  (in_data_i),
        .sh_busy    (sh_busy),
        .poll_active(poll_active),
        .in_ready_o (in_ready_o),
        .chip_en_o  (chip_en_o),
        .sh_start   (sh_start),
        .sh_word    (sh_word),
        .poll_start (poll_start)
    );

    word_shifter #(.HALF_DIV(HALF_DIV)) i_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (sh_start),
        .word   (sh_word),
        .busy   (sh_busy),
        .sclk_o (ser_clk_o),
        .sdata_o(ser_data_o),
        .le_o   (ser_le_o)
    );

    lock_poll #(.POLL_CYCLES(POLL_CYCLES)) i_poll (
        .clk       (clk),
        .rst_n     (rst_n),
        .poll_start(poll_start),
        .lock_raw  (lock_det_i),
        .active    (poll_active),
        .locked_o  (locked_o),
        .timeout_o (timeout_o)
    );
endmodule

// File: rtl/synth_prog_ctrl_chk.sv
// Port-level protocol checks for synth_prog_ctrl, attached by bind below.
module synth_prog_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic pwr_on_i,
    input logic in_ready_o,
    input logic ser_clk_o,
    input logic ser_data_o,
    input logic ser_le_o,
    input logic chip_en_o,
    input logic locked_o,
    input logic timeout_o
);
    // R3: data holds through the whole high phase of the serial clock
    a_r3_data_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk_o && $past(ser_clk_o)) |-> $stable(ser_data_o));

    // R3: data is already settled when the serial clock rises
    a_r3_data_before_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk_o) |-> $stable(ser_data_o));

    // R4: the latch strobe never overlaps a high serial clock
    a_r4_strobe_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        ser_le_o |-> !ser_clk_o);

    // R5: while ready, the serial pins are quiet
    a_r5_ready_pins_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready_o |-> (!ser_le_o && !ser_clk_o));

    // R6: a poll yields at most one outcome
    a_r6_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        !(locked_o && timeout_o));

    // R8: ready implies the device is powered and power is requested
    a_r8_ready_powered: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready_o |-> (chip_en_o && pwr_on_i));

    // R8: chip enable only falls after power was withdrawn
    a_r8_ce_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chip_en_o) |-> !$past(pwr_on_i));
endmodule

bind synth_prog_ctrl synth_prog_ctrl_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_on_i  (pwr_on_i),
    .in_ready_o(in_ready_o),
    .ser_clk_o (ser_clk_o),
    .ser_data_o(ser_data_o),
    .ser_le_o  (ser_le_o),
    .chip_en_o (chip_en_o),
    .locked_o  (locked_o),
    .timeout_o (timeout_o)
);

// File: tb/test_synth_prog_ctrl.sv
// Bench: behavioural per-clock pin model plus directed checks on decoded serial words.
module test_synth_prog_ctrl;
    localparam int unsigned HD = 2;
    localparam int unsigned PC = 40;
    localparam logic [23:0] W_INIT = 24'h0D8093;
    localparam logic [23:0] W_R    = 24'h100050;
    localparam logic [23:0] W_N    = 24'h003201;
    localparam int XFER_T = (2 * 24 + 3) * HD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_on = 1'b0;
    logic        in_valid = 1'b0;
    logic [23:0] in_data = '0;
    logic        lock_det = 1'b0;
    logic        in_ready, sclk, sdata, le, ce, locked, tmo;

    synth_prog_ctrl #(
        .SYS_CLK_HZ(50_000_000), .HALF_DIV(HD), .POLL_CYCLES(PC),
        .INIT_WORD(W_INIT), .RCNT_WORD(W_R), .NCNT_WORD(W_N)
    ) i_synth_prog_ctrl (
        .clk(clk), .rst_n(rst_n), .pwr_on_i(pwr_on), .in_valid_i(in_valid),
        .in_data_i(in_data), .in_ready_o(in_ready), .ser_clk_o(sclk),
        .ser_data_o(sdata), .ser_le_o(le), .chip_en_o(ce),
        .lock_det_i(lock_det), .locked_o(locked), .timeout_o(tmo)
    );

    always #10 clk = ~clk;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference model: 0 off, 1 about to launch, 2 shifting, 3 idle.
    int          m_mode = 0;
    int          m_t = 0;
    logic [23:0] m_word = '0;
    logic [23:0] m_q[$];
    bit          m_poll = 0, m_locked = 0, m_tmo = 0, m_h1 = 0, m_h2 = 0, m_lk = 0, m_was = 0;
    int          m_pc = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_poll = 0; m_locked = 0; m_tmo = 0; m_h1 = 0; m_h2 = 0;
            m_q.delete();
        end else begin
            m_lk = m_h2; m_h2 = m_h1; m_h1 = lock_det;
            m_was = m_poll;
            if (m_poll) begin
                m_pc++;
                if (m_lk) begin m_locked = 1; m_poll = 0; end
                else if (m_pc == PC) begin m_tmo = 1; m_poll = 0; end
            end
            case (m_mode)
                0: if (pwr_on) begin m_mode = 1; m_q = '{W_INIT, W_R, W_N}; end
                1: begin m_word = m_q.pop_front(); m_mode = 2; m_t = 0; end
                2: begin
                    m_t++;
                    if (m_t == XFER_T + 1) begin
                        if (m_word[1:0] == 2'b01) begin
                            m_poll = 1; m_pc = 0; m_locked = 0; m_tmo = 0;
                        end
                        m_mode = (m_q.size() > 0) ? 1 : 3;
                    end
                end
                default: if (!m_was) begin
                    if (!pwr_on) m_mode = 0;
                    else if (in_valid) begin m_word = in_data; m_mode = 2; m_t = 0; end
                end
            endcase
        end
    end

    // Per-clock comparison of every output against the model, sampled mid-cycle.
    logic [6:0] e_v, a_v;
    int hh;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            e_v = '0;
            if (m_mode == 2 && m_t >= 1 && m_t <= XFER_T) begin
                hh = (m_t - 1) / HD;
                e_v[6] = (hh < 48) && (hh % 2 == 1);
                e_v[5] = (hh < 48) ? m_word[23 - hh / 2] : 1'b0;
                e_v[4] = (hh == 48) || (hh == 49);
            end
            e_v[3] = (m_mode == 3) && !m_poll && pwr_on;
            e_v[2] = (m_mode != 0);
            e_v[1] = m_locked;
            e_v[0] = m_tmo;
            a_v = {sclk, sdata, le, in_ready, ce, locked, tmo};
            tests++;
            if (a_v !== e_v) begin
                fails++;
                $display("FAIL %s cycle compare: actual %b expected %b",
                    (a_v[6:5] !== e_v[6:5]) ? "R3" : (a_v[4] !== e_v[4]) ? "R4" :
                    (a_v[3] !== e_v[3]) ? "R5" : (a_v[2] !== e_v[2]) ? "R8" : "R6",
                    a_v, e_v);
            end
        end
    end

    // Serial capture: sample data on each rising serial clock, close a word on the strobe.
    logic [23:0] cap_sr = '0;
    int          cap_n = 0;
    int          le_len = 0;
    logic        p_sclk = 0, p_le = 0;
    logic [23:0] capq[$];
    always @(negedge clk) begin
        if (rst_n) begin
            if (sclk && !p_sclk) begin cap_sr = {cap_sr[22:0], sdata}; cap_n++; end
            if (le && !p_le) begin
                chk("R4 bits before strobe", cap_n, 24);
                capq.push_back(cap_sr);
                cap_n = 0;
            end
            if (le) le_len++;
            if (!le && p_le) begin
                chk("R4 strobe width", le_len, 2 * HD);
                le_len = 0;
            end
        end
        p_sclk = sclk;
        p_le = le;
    end

    task automatic wait_ready();
        forever begin @(negedge clk); if (in_ready) break; end
    endtask

    task automatic send(input logic [23:0] w);
        @(posedge clk); #2;
        in_valid = 1'b1; in_data = w;
        forever begin @(negedge clk); if (in_ready) break; end
        @(posedge clk); #2;
        in_valid = 1'b0;
    endtask

    task automatic drive_after_edge();
        @(posedge clk); #2;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1 reset outputs", {25'b0, ce, in_ready, sclk, sdata, le, locked, tmo}, 32'h0);
        drive_after_edge(); rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 idle after reset", {25'b0, ce, in_ready, sclk, sdata, le, locked, tmo}, 32'h0);

        // R2: power-up writes in order, then poll finds lock
        lock_det = 1'b1;
        drive_after_edge(); pwr_on = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R2 chip enable raised", ce, 1);
        wait_ready();
        chk("R2 three power-up words", capq.size(), 3);
        if (capq.size() == 3) begin
            chk("R2 first word init latch", capq[0], W_INIT);
            chk("R2 second word R latch", capq[1], W_R);
            chk("R2 third word N latch", capq[2], W_N);
        end
        chk("R6 locked after power-up", {locked, tmo}, 2'b10);
        capq.delete();

        // R7: non-N words keep flags and skip the poll
        send(24'hA5C330);
        send(24'h5A3C92);
        wait_ready();
        chk("R7 words captured", capq.size(), 2);
        if (capq.size() == 2) begin
            chk("R3 R-latch word bits", capq[0], 24'hA5C330);
            chk("R3 function word bits", capq[1], 24'h5A3C92);
        end
        chk("R7 flags kept", {locked, tmo}, 2'b10);
        capq.delete();

        // R6 timeout, with R5 a word held while the poll runs
        drive_after_edge(); lock_det = 1'b0;
        send(24'h0C8405);
        send(24'h3FFFE3);
        chk("R6 timeout flagged", {locked, tmo}, 2'b01);
        wait_ready();
        chk("R5 held word sent after poll", capq.size(), 2);
        if (capq.size() == 2) chk("R5 held word bits", capq[1], 24'h3FFFE3);
        chk("R7 timeout kept", {locked, tmo}, 2'b01);
        capq.delete();

        // R6: lock arrives part way through the window
        send(24'h812341);
        repeat (XFER_T + 10) @(posedge clk);
        #2 lock_det = 1'b1;
        wait_ready();
        chk("R6 late lock", {locked, tmo}, 2'b10);

        // R8: power-down from idle
        drive_after_edge(); pwr_on = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R8 chip enable low", {ce, in_ready}, 2'b00);

        // R9: repower reruns the sequence
        capq.delete();
        drive_after_edge(); pwr_on = 1'b1;
        wait_ready();
        chk("R9 repeat count", capq.size(), 3);
        if (capq.size() == 3) chk("R9 repeat order", {capq[0][1:0], capq[1][1:0], capq[2][1:0]}, 6'b110001);

        // R8: power-down during a transfer waits for the word
        send(24'h123450);
        repeat (10) @(posedge clk);
        #2 pwr_on = 1'b0;
        @(negedge clk);
        chk("R8 held during transfer", ce, 1);
        repeat (XFER_T + 4) @(negedge clk);
        chk("R8 off after transfer", ce, 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule